// File: doc/BRIEF.md
# Wait-State Memory Slave for a Pipelined System Bus

This block is a target on the AMBA AHB system bus. It holds a small register memory of 32-bit words. Each transfer has two phases. In the address phase the slave takes in the address and control for one clock. In the data phase it holds its ready output low for a fixed, parameterised number of cycles before it ends the transfer. The address phase of the next transfer overlaps the last cycle of the current data phase, so back-to-back accesses run without a gap cycle.

The slave accepts 8-bit, 16-bit and 32-bit accesses. A narrow write changes only the byte lanes it selects. A transfer marked idle or busy is finished at once with an OKAY response and no wait cycle. A request that is wider than a word, misaligned, or outside the memory is refused with the usual two-cycle ERROR response and leaves the memory untouched.

The wait count comes from the parameter `WAIT_STATES`. It is clamped to 16 cycles, so a transfer is never stretched for longer than the protocol allows. Beats of a burst carry their own address, so the slave needs no burst-type input.

Top module: `ahb_wait_mem`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `ready_out` is 1, `resp` is 0 and `rdata` is 0. The memory words all read as zero.
- R2: A transfer is accepted only in a cycle where `sel`, `ready_in` and `trans[1]` are all 1. In any other cycle the address, control and `wdata` have no effect: `ready_out` stays 1 and no word is written.
- R3: A selected transfer of type IDLE (`trans`=00) or BUSY (`trans`=01) gets `ready_out`=1 and `resp`=0 in the following cycle, and it writes nothing.
- R4: An accepted legal transfer (`trans`=10 NONSEQ or 11 SEQ) holds `ready_out` low with `resp`=0 for exactly min(`WAIT_STATES`,16) cycles after its address phase. The cycle after that has `ready_out`=1.
- R5: When `WAIT_STATES` is larger than 16, every legal transfer waits exactly 16 cycles.
- R6: A write takes `wdata` in the data-phase cycle where `ready_out` is 1. `size` 000 writes one byte, 001 writes two bytes and 010 writes four bytes. The bytes written start at lane `addr[1:0]`, where lane k is `wdata[8k+7:8k]`. All other lanes keep their value.
- R7: During the data phase of a read, `rdata` carries the whole 32-bit word at `addr[IDX_W+1:2]`, whatever the access size. Outside a read data phase, `rdata` is 0.
- R8: The next address phase is taken on the same edge that completes the current data phase. A read placed right after a write to the same word returns the newly written value.
- R9: A transfer is refused if `size` is above 010, or the address is not a multiple of the access size, or any address bit above `IDX_W+1` is set. The refusal gives one cycle with `ready_out`=0 and `resp`=1, then one cycle with `ready_out`=1 and `resp`=1. Memory is not changed.
- R10: `resp` is 1 (ERROR) only in the two cycles of a refusal, and 0 (OKAY) in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Slave select from the address decoder |
| addr | input | ADDR_W | Byte address of the address phase |
| trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 first beat, 11 following beat |
| write | input | 1 | 1 write, 0 read |
| size | input | 3 | Log2 of access bytes |
| wdata | input | 32 | Write data, valid in the data phase |
| ready_in | input | 1 | Bus-wide ready; address phases are taken only when high |
| rdata | output | 32 | Read data |
| ready_out | output | 1 | Low stretches the data phase, high ends it |
| resp | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The main function is tried with word writes, with byte writes in lanes 1 and 3, and with a halfword write in the upper half. Each is followed by word, halfword and byte reads, so that lane masking can be told apart from full-word overwrites. The refused patterns are a misaligned halfword, a doubleword size and an out-of-range address. Each is followed by a read of the word it could have touched, which separates refusal from a silent write. Idle, busy, deselected and stalled-bus cycles carry write data, so that any leak shows up in a later read. A write followed at once by a read of the same word, and a second instance with a wait count of 20, show pipelined hand-over and the 16-cycle clamp.

// File: rtl/ahb_wm_pkg.sv
`timescale 1ns/1ps
package ahb_wm_pkg;

  localparam int unsigned WAIT_CAP   = 16;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_DATA,
    PH_ERR1,
    PH_ERR2
  } phase_e;

  function automatic int unsigned clamp_wait(input int unsigned w);
    return (w > WAIT_CAP) ? WAIT_CAP : w;
  endfunction

  function automatic logic size_ok(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  function automatic logic aligned(input logic [1:0] a, input logic [2:0] s);
    case (s)
      3'd1:    return ~a[0];
      3'd2:    return a == 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [1:0] a, input logic [2:0] s);
    case (s)
      3'd0:    return 4'b0001 << a;
      3'd1:    return 4'b0011 << a;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/ahb_wm_addr_stage.sv
`timescale 1ns/1ps
module ahb_wm_addr_stage
  import ahb_wm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  ready_in,
  input  logic [1:0]            trans,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  write,
  input  logic [2:0]            size,
  output logic                  accept,
  output logic                  start_ok,
  output logic                  start_err,
  output logic [IDX_W-1:0]      idx_q,
  output logic [WORD_BYTES-1:0] lanes_q,
  output logic                  write_q
);

  logic in_range;
  logic legal;

  always_comb begin
    accept    = sel && ready_in && trans[1];
    in_range  = (addr >> (IDX_W + 2)) == '0;
    legal     = size_ok(size) && aligned(addr[1:0], size) && in_range;
    start_ok  = accept && legal;
    start_err = accept && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      lanes_q <= '0;
      write_q <= 1'b0;
    end else if (start_ok) begin
      idx_q   <= addr[IDX_W+1:2];
      lanes_q <= lane_mask(addr[1:0], size);
      write_q <= write;
    end
  end

endmodule

// File: rtl/ahb_wm_wait_ctrl.sv
`timescale 1ns/1ps
module ahb_wm_wait_ctrl
  import ahb_wm_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic start_err,
  output logic ready_o,
  output logic resp_o,
  output logic in_data,
  output logic commit
);

  localparam int unsigned W_EFF = clamp_wait(WAIT_STATES);
  localparam int unsigned CW    = $clog2(WAIT_CAP + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ready_o = (ph_q == PH_IDLE) || (ph_q == PH_ERR2) ||
              ((ph_q == PH_DATA) && (cnt_q == '0));
    resp_o  = (ph_q == PH_ERR1) || (ph_q == PH_ERR2);
    in_data = (ph_q == PH_DATA);
    commit  = in_data && (cnt_q == '0);

    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_ERR1) begin
      ph_d = PH_ERR2;
    end else if ((ph_q == PH_DATA) && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end else if (start_err) begin
      ph_d = PH_ERR1;
    end else if (start_ok) begin
      ph_d  = PH_DATA;
      cnt_d = CW'(W_EFF);
    end else begin
      ph_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ahb_wm_mem.sv
`timescale 1ns/1ps
module ahb_wm_mem
  import ahb_wm_pkg::*;
#(
  parameter int unsigned WORDS = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [WORD_BYTES-1:0]   lanes,
  input  logic [IDX_W-1:0]        idx,
  input  logic [8*WORD_BYTES-1:0] wdata,
  output logic [8*WORD_BYTES-1:0] rdata
);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    logic [7:0] store_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) store_q[w] <= '0;
      end else if (we && lanes[b]) begin
        store_q[idx] <= wdata[8*b +: 8];
      end
    end

    assign rdata[8*b +: 8] = store_q[idx];
  end

endmodule

// File: rtl/ahb_wait_mem.sv
`timescale 1ns/1ps
module ahb_wait_mem
  import ahb_wm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned MEM_WORDS   = 16,
  parameter int unsigned WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic [31:0]       wdata,
  input  logic              ready_in,
  output logic [31:0]       rdata,
  output logic              ready_out,
  output logic              resp
);

  localparam int unsigned IDX_W = $clog2(MEM_WORDS);

  logic                  xfer_accept;
  logic                  start_ok, start_err;
  logic [IDX_W-1:0]      idx_q;
  logic [WORD_BYTES-1:0] lanes_q;
  logic                  write_q;
  logic                  in_data, commit;
  logic [31:0]           mem_rd;

  ahb_wm_addr_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ready_in(ready_in),
    .trans(trans), .addr(addr), .write(write), .size(size),
    .accept(xfer_accept), .start_ok(start_ok), .start_err(start_err),
    .idx_q(idx_q), .lanes_q(lanes_q), .write_q(write_q)
  );

  ahb_wm_wait_ctrl #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_err(start_err),
    .ready_o(ready_out), .resp_o(resp), .in_data(in_data), .commit(commit)
  );

  ahb_wm_mem #(.WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit && write_q), .lanes(lanes_q),
    .idx(idx_q), .wdata(wdata), .rdata(mem_rd)
  );

  assign rdata = (in_data && !write_q) ? mem_rd : '0;

endmodule

// File: rtl/ahb_wait_mem_chk.sv
`timescale 1ns/1ps
module ahb_wait_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready_out,
  input logic       resp,
  input logic       xfer_accept
);

  logic [4:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (ready_out)      low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 5'd1;
  end

  // R3 and R2: a cycle without an accepted transfer leaves the next cycle ready and OKAY
  a_r3_idle_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_out && !xfer_accept) |=> (ready_out && !resp));

  // R9: first refusal cycle is followed by the ready ERROR cycle
  a_r9_err_second: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && !ready_out) |=> (resp && ready_out));

  // R9: an ERROR response starts with ready low
  a_r9_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    (resp && !$past(resp)) |-> !ready_out);

  // R4 and R10: wait cycles stay OKAY
  a_r4_wait_okay: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_out && !resp) |=> !resp);

  // R5: no stretch longer than 16 cycles
  a_r5_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 5'd16);

endmodule

bind ahb_wait_mem ahb_wait_mem_chk u_chk (.*);

// File: tb/ahb_wait_mem_tb.sv
`timescale 1ns/1ps
module ahb_wait_mem_tb;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [31:0] a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd2, 32'h00, 32'h11223344},
    '{1'b0, 3'd2, 32'h00, 32'h0},
    '{1'b1, 3'd0, 32'h01, 32'h0000AA00},
    '{1'b0, 3'd2, 32'h00, 32'h0},
    '{1'b1, 3'd1, 32'h06, 32'hBEEF0000},
    '{1'b0, 3'd1, 32'h06, 32'h0},
    '{1'b1, 3'd1, 32'h05, 32'h12345678},
    '{1'b0, 3'd2, 32'h04, 32'h0},
    '{1'b1, 3'd3, 32'h08, 32'hCAFEF00D},
    '{1'b1, 3'd2, 32'h3C, 32'hDEADBEEF},
    '{1'b0, 3'd0, 32'h3D, 32'h0},
    '{1'b0, 3'd2, 32'h40, 32'h0},
    '{1'b0, 3'd2, 32'h20, 32'h0},
    '{1'b1, 3'd0, 32'h03, 32'h77000000},
    '{1'b0, 3'd2, 32'h00, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        write = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [31:0] wdata = '0;
  logic        hold_low = 1'b0;
  logic        ready_in, ready_out, resp;
  logic [31:0] rdata;
  logic        cap_ready, cap_resp;
  logic [31:0] cap_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] bm [16];

  always #2 clk = ~clk;

  assign ready_in = ready_out & ~hold_low;

  ahb_wait_mem u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .trans(trans),
    .write(write), .size(size), .wdata(wdata), .ready_in(ready_in),
    .rdata(rdata), .ready_out(ready_out), .resp(resp)
  );

  ahb_wait_mem #(.WAIT_STATES(20)) u_dut_cap (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .trans(trans),
    .write(write), .size(size), .wdata(wdata), .ready_in(cap_ready),
    .rdata(cap_rdata), .ready_out(cap_ready), .resp(cap_resp)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] tr, input logic wr, input logic [2:0] sz,
                      input logic [31:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic r_first, output logic r_last,
                      output int lows);
    @(negedge clk);
    sel = 1'b1; trans = tr; addr = a; write = wr; size = sz;
    @(negedge clk);
    sel = 1'b0; trans = 2'b00; wdata = wd;
    lows = 0;
    r_first = resp;
    while (!ready_out && lows < 40) begin
      lows++;
      @(negedge clk);
    end
    rd = rdata;
    r_last = resp;
  endtask

  function automatic logic model_err(input logic [2:0] sz, input logic [31:0] a);
    int nb;
    if (sz > 3'd2) return 1'b1;
    nb = 1 << sz;
    return ((a % nb) != 0) || (a >= 32'd64);
  endfunction

  task automatic model_write(input logic [2:0] sz, input logic [31:0] a, input logic [31:0] d);
    int nb, lo;
    nb = 1 << sz;
    lo = int'(a[1:0]);
    for (int k = 0; k < 4; k++)
      if (k >= lo && k < lo + nb) bm[a[5:2]][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic rf, rl;
    int lows;
    for (int i = 0; i < 16; i++) bm[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ready_out == 1'b1 && resp == 1'b0, "R1 reset ready/resp", {30'd0, ready_out, resp}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_out && !resp && rdata == 32'h0, "R1 after release", rdata, 32'h0);

    // R4 R6 R7 R9 R10: vector table
    for (int i = 0; i < NV; i++) begin
      logic e;
      e = model_err(VECS[i].sz, VECS[i].a);
      xfer(2'b10, VECS[i].wr, VECS[i].sz, VECS[i].a, VECS[i].d, rd, rf, rl, lows);
      if (e) begin
        chk(lows == 1 && rf && rl, "R9 refusal two cycles", {lows[29:0], rf, rl}, {30'd1, 2'b11});
      end else begin
        chk(lows == 2 && !rf && !rl, "R4 R10 two OKAY waits", {lows[29:0], rf, rl}, {30'd2, 2'b00});
        if (VECS[i].wr) model_write(VECS[i].sz, VECS[i].a, VECS[i].d);
        else chk(rd == bm[VECS[i].a[5:2]], "R7 R6 read word", rd, bm[VECS[i].a[5:2]]);
      end
    end

    // R3: BUSY and IDLE with write data do nothing
    xfer(2'b01, 1'b1, 3'd2, 32'h0, 32'hFFFFFFFF, rd, rf, rl, lows);
    chk(lows == 0 && !rl, "R3 busy zero wait", lows, 32'd0);
    xfer(2'b00, 1'b1, 3'd2, 32'h0, 32'hFFFFFFFF, rd, rf, rl, lows);
    chk(lows == 0 && !rl, "R3 idle zero wait", lows, 32'd0);
    xfer(2'b10, 1'b0, 3'd2, 32'h0, 32'h0, rd, rf, rl, lows);
    chk(rd == bm[0], "R3 no write by busy/idle", rd, bm[0]);

    // R2: deselected and stalled-bus cycles are ignored
    @(negedge clk);
    sel = 1'b0; trans = 2'b10; write = 1'b1; addr = 32'h0; size = 3'd2;
    @(negedge clk);
    chk(ready_out == 1'b1, "R2 sel low ignored", {31'd0, ready_out}, 32'd1);
    trans = 2'b00; wdata = 32'hEEEEEEEE;
    @(negedge clk);
    hold_low = 1'b1; sel = 1'b1; trans = 2'b10; write = 1'b1;
    @(negedge clk);
    chk(ready_out == 1'b1, "R2 ready_in low ignored", {31'd0, ready_out}, 32'd1);
    sel = 1'b0; trans = 2'b00; hold_low = 1'b0; wdata = 32'hDDDDDDDD;
    xfer(2'b10, 1'b0, 3'd2, 32'h0, 32'h0, rd, rf, rl, lows);
    chk(rd == bm[0], "R2 no write while ignored", rd, bm[0]);

    // R8: back-to-back write then SEQ read of same word
    @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b1; addr = 32'h10; size = 3'd2;
    @(negedge clk);
    wdata = 32'h5A5A5A5A;
    trans = 2'b11; write = 1'b0; addr = 32'h10;
    lows = 0;
    while (!ready_out && lows < 40) begin lows++; @(negedge clk); end
    chk(lows == 2, "R8 first data phase waits", lows, 32'd2);
    @(negedge clk);
    sel = 1'b0; trans = 2'b00;
    lows = 0;
    while (!ready_out && lows < 40) begin lows++; @(negedge clk); end
    chk(lows == 2, "R8 overlapped read waits", lows, 32'd2);
    chk(rdata == 32'h5A5A5A5A, "R8 read sees new write", rdata, 32'h5A5A5A5A);
    bm[4] = 32'h5A5A5A5A;
    @(negedge clk);
    chk(rdata == 32'h0, "R7 rdata zero outside data phase", rdata, 32'h0);

    // R5: wait clamp on the instance configured for 20
    repeat (40) @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b0; addr = 32'h0; size = 3'd2;
    @(negedge clk);
    sel = 1'b0; trans = 2'b00;
    lows = 0;
    while (!cap_ready && lows < 40) begin lows++; @(negedge clk); end
    chk(lows == 16 && !cap_resp, "R5 wait clamped to 16", lows, 32'd16);

    // R1: reset during a wait
    repeat (20) @(negedge clk);
    sel = 1'b1; trans = 2'b10; write = 1'b0; addr = 32'h3C;
    @(negedge clk);
    sel = 1'b0; trans = 2'b00;
    chk(ready_out == 1'b0, "R4 in wait before reset", {31'd0, ready_out}, 32'd0);
    rst_n = 1'b0;
    #1;
    chk(ready_out && !resp && rdata == 32'h0, "R1 reset mid-transfer", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    xfer(2'b10, 1'b0, 3'd2, 32'h3C, 32'h0, rd, rf, rl, lows);
    chk(rd == 32'h0, "R1 memory cleared by reset", rd, 32'h0);

    finish_run();
  end

endmodule